// File: doc/BRIEF.md
# Serial Port Transmit and Receive FIFO Pair

This block holds the character buffering for one serial port. A transmit queue of 16 bytes is filled by software through a write window and drained one byte at a time by the transmit shifter. A receive queue of 16 entries is filled by the receive shifter, each entry being a data byte plus a parity-error flag and a framing-error flag. Software drains it through a read window. Serial shifting and baud timing live in neighbouring blocks and are not part of this one.

Software sees two registers. The level register reports how many entries each queue holds. The queue control register carries a global enable and two flush bits. A flush bit reads back as one while its flush is in progress and then clears itself. Hardware events flag transmit underrun, receive overrun, a low transmit level and a high receive level. A read of the empty receive window can optionally answer with a bus error. That option is selected by a line-control bit owned by a neighbouring block, which drives it into this block as an input.

The bus is a single-cycle access port. Read data and the error flag are valid in the same cycle as the select. A read of the receive window removes the head entry at the clock edge that ends the access.

Top module: `serial_fifo_pair`

## Requirements
- R1: After reset both queues are empty, so the level register reads 0. The control register reads 0 (queues disabled), `tx_valid`, `rx_level_high`, `ev_overrun` and `ev_underrun` are 0, and `tx_level_low` is 1.
- R2: While enabled, a write to the transmit window (byte address 0x20..0x3F) appends `bus_wdata[7:0]`. The shifter receives the bytes in write order on `tx_byte`, one per cycle with `tx_take` high, and `tx_valid` is high whenever the queue holds a byte. The level register bits 4:0 give the transmit count, and a count below 16 means there is room.
- R3: While enabled, `rx_strobe` stores `{rx_frame_err, rx_parity_err, rx_char}` as one entry. A read of the receive window (byte address 0x40..0x5F) returns the head entry with data in bits 7:0, the parity flag in bit 8 and the framing flag in bit 9, and removes it. The level register bits 12:8 give the receive count.
- R4: A write to the transmit window while it holds 16 bytes is ignored: the count stays 16 and the stored bytes and their order are unchanged.
- R5: `rx_strobe` while the receive queue holds 16 entries drops the character and raises `ev_overrun` for exactly the following cycle.
- R6: `tx_take` while the transmit queue is empty (and enabled) changes nothing and raises `ev_underrun` for exactly the following cycle.
- R7: A read of the empty receive window returns 0 and leaves the count at 0. `bus_err` is high in that cycle only when `empty_rd_err_en` is 1.
- R8: Writing the control register (address 0x00) with bit 2 flushes the transmit queue and with bit 3 flushes the receive queue. Each such bit reads back as 1 for CLR_CYCLES cycles after the write, then reads back as 0 with that queue empty. A flush of one queue leaves the other intact.
- R9: Control bit 0 enables the queues. While it is 0, transmit-window writes and `rx_strobe` store nothing and `tx_valid` stays low.
- R10: `tx_level_low` is high exactly when the transmit count is 4 or less. `rx_level_high` is high exactly when the receive count is 12 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Error response for an empty receive-window read |
| empty_rd_err_en | input | 1 | Line-control option: error on empty receive read |
| tx_byte | output | 8 | Head byte of the transmit queue |
| tx_valid | output | 1 | Transmit queue holds a byte and is usable |
| tx_take | input | 1 | Shifter removes the head byte |
| rx_strobe | input | 1 | Shifter delivers a received character |
| rx_char | input | 8 | Received data byte |
| rx_parity_err | input | 1 | Parity check failed for this character |
| rx_frame_err | input | 1 | Stop bit missing for this character |
| tx_level_low | output | 1 | Transmit count at or below the low mark |
| rx_level_high | output | 1 | Receive count at or above the high mark |
| ev_overrun | output | 1 | One-cycle pulse: received character dropped |
| ev_underrun | output | 1 | One-cycle pulse: take from empty transmit queue |

## Verification
The assertions assume that the bus issues at most one access per cycle and that `tx_take` is only meaningful while the block is enabled. They also assume that no queue entry is used before it has been written. The bench keeps within these assumptions in three ways. Every stimulus is driven on the falling edge and released one nanosecond after the rising edge, so each access lasts exactly one cycle. The queues are enabled before any byte is pushed. Nothing is read out of either queue beyond what the bench has counted in.

// File: rtl/sfp_pkg.sv
// Package: shared constants for the serial FIFO pair.
// Holds the address map, control bit positions, level-register field
// positions and the receive entry layout. Widths are fixed for the
// character path; depths and marks are parameters of the top.
package sfp_pkg;

    localparam int CHAR_W     = 8;
    localparam int BUS_W      = 32;

    // address regions on bits 6:5 of the byte address
    localparam logic [1:0] REGION_REGS = 2'b00;
    localparam logic [1:0] REGION_TXW  = 2'b01;
    localparam logic [1:0] REGION_RXW  = 2'b10;

    // register select within the register region on bits 4:2
    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_LEVEL = 3'd1;

    // control register bit positions
    localparam int CTL_EN      = 0;
    localparam int CTL_TXFLUSH = 2;
    localparam int CTL_RXFLUSH = 3;

    // level register field base positions
    localparam int LVL_TX_LSB = 0;
    localparam int LVL_RX_LSB = 8;

    // one received character with its line error flags
    typedef struct packed {
        logic              frame_err;
        logic              parity_err;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

    localparam int RX_ENTRY_W = $bits(rx_entry_t);

endpackage

// File: rtl/sfp_fifo.sv
// Module: sfp_fifo
// Synchronous single-clock queue with a fill count.
// Assumes: a push into a full queue and a pop from an empty queue are
// refused (the caller reports them); a push is only taken when the queue
// is not full, even if a pop happens in the same cycle. 'clr' empties the
// queue and wins over push and pop.
module sfp_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    // gate requests by state so refused operations leave no trace
    always_comb begin
        do_push = push && !full && !clr;
        do_pop  = pop && !empty && !clr;
    end

    // status derived from the count
    always_comb begin
        full  = (count == CW'(DEPTH));
        empty = (count == '0);
        rdata = mem[rd_ptr];
    end

    // storage write: only accepted pushes touch the array
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // write pointer with wrap at the last slot
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
        end else if (do_push) begin
            wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        end
    end

    // read pointer with wrap at the last slot
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr <= '0;
        end else if (do_pop) begin
            rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    // fill count follows accepted pushes and pops
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else begin
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R4: the count never exceeds the depth
    p_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R4: a push alone into a full queue leaves it full
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> full);

    // R6: a pop alone from an empty queue leaves it empty
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clr) |=> empty);

    // R8: a clear empties the queue on the next cycle
    p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);

endmodule

// File: rtl/sfp_flush_timer.sv
// Module: sfp_flush_timer
// Holds a flush request active for a fixed number of cycles so that a
// self-clearing control bit can report progress.
// Assumes: 'start' is a one-cycle pulse; a new start while busy restarts
// the window. CYCLES must be at least 1.
module sfp_flush_timer #(
    parameter int CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] left;

    // load on start, count down to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
        end else if (start) begin
            left <= TW'(CYCLES);
        end else if (left != '0) begin
            left <= left - 1'b1;
        end
    end

    // busy for as long as the window lasts
    always_comb begin
        busy = (left != '0);
    end

    // R8: the remaining window never exceeds its length
    p_window_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        left <= TW'(CYCLES));

    // R8: a start always opens a window
    p_start_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

endmodule

// File: rtl/serial_fifo_pair.sv
// Module: serial_fifo_pair (top)
// Transmit byte queue and receive entry queue for one serial port, with a
// level register, a control register (enable plus self-clearing flushes)
// and overrun / underrun / level events.
// Assumes: single-cycle bus accesses, read data used in the access cycle;
// a receive-window read removes the head entry at the closing edge.
module serial_fifo_pair
    import sfp_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int LOW_MARK   = 4,
    parameter int HIGH_MARK  = 12,
    parameter int CLR_CYCLES = 2,
    parameter int ADDR_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_err,
    input  logic              empty_rd_err_en,
    output logic [CHAR_W-1:0] tx_byte,
    output logic              tx_valid,
    input  logic              tx_take,
    input  logic              rx_strobe,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_parity_err,
    input  logic              rx_frame_err,
    output logic              tx_level_low,
    output logic              rx_level_high,
    output logic              ev_overrun,
    output logic              ev_underrun
);

    localparam int CW     = $clog2(DEPTH + 1);
    localparam int NQ     = 2;
    localparam int Q_TX   = 0;
    localparam int Q_RX   = 1;

    // decoded access strobes
    logic [1:0] region;
    logic [2:0] reg_sel;
    logic       wr_ctrl;
    logic       wr_txw;
    logic       rd_rxw;
    logic       rd_ctrl;
    logic       rd_level;

    // control state
    logic          q_en;
    logic [NQ-1:0] flush_start;
    logic [NQ-1:0] flush_busy;

    // queue signals
    logic                  tx_push;
    logic                  tx_pop;
    logic [CHAR_W-1:0]     tx_head;
    logic [CW-1:0]         tx_cnt;
    logic                  tx_full;
    logic                  tx_empty;
    logic                  rx_push;
    logic                  rx_pop;
    rx_entry_t             rx_in;
    rx_entry_t             rx_head;
    logic [CW-1:0]         rx_cnt;
    logic                  rx_full;
    logic                  rx_empty;

    // event registers
    logic ovr_q;
    logic und_q;

    // address decode into one-hot access strobes
    always_comb begin
        region   = bus_addr[6:5];
        reg_sel  = bus_addr[4:2];
        wr_ctrl  = bus_sel && bus_wr && (region == REGION_REGS) && (reg_sel == SEL_CTRL);
        wr_txw   = bus_sel && bus_wr && (region == REGION_TXW);
        rd_rxw   = bus_sel && !bus_wr && (region == REGION_RXW);
        rd_ctrl  = bus_sel && !bus_wr && (region == REGION_REGS) && (reg_sel == SEL_CTRL);
        rd_level = bus_sel && !bus_wr && (region == REGION_REGS) && (reg_sel == SEL_LEVEL);
    end

    // enable bit holds whatever the last control write carried
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_en <= 1'b0;
        end else if (wr_ctrl) begin
            q_en <= bus_wdata[CTL_EN];
        end
    end

    // flush requests come straight from the control write
    always_comb begin
        flush_start[Q_TX] = wr_ctrl && bus_wdata[CTL_TXFLUSH];
        flush_start[Q_RX] = wr_ctrl && bus_wdata[CTL_RXFLUSH];
    end

    // one self-clearing flush window per queue
    for (genvar q = 0; q < NQ; q++) begin : g_flush
        sfp_flush_timer #(
            .CYCLES (CLR_CYCLES)
        ) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .start (flush_start[q]),
            .busy  (flush_busy[q])
        );
    end

    // queue request gating: disabled queues accept nothing
    always_comb begin
        tx_push = wr_txw && q_en;
        tx_pop  = tx_take && q_en;
        rx_push = rx_strobe && q_en;
        rx_pop  = rd_rxw;
        rx_in.frame_err  = rx_frame_err;
        rx_in.parity_err = rx_parity_err;
        rx_in.data       = rx_char;
    end

    // transmit queue: bytes only
    sfp_fifo #(
        .WIDTH (CHAR_W),
        .DEPTH (DEPTH),
        .CW    (CW)
    ) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush_busy[Q_TX]),
        .push  (tx_push),
        .wdata (bus_wdata[CHAR_W-1:0]),
        .pop   (tx_pop),
        .rdata (tx_head),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    // receive queue: byte plus line error flags
    sfp_fifo #(
        .WIDTH (RX_ENTRY_W),
        .DEPTH (DEPTH),
        .CW    (CW)
    ) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush_busy[Q_RX]),
        .push  (rx_push),
        .wdata (rx_in),
        .pop   (rx_pop),
        .rdata (rx_head),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    // one-cycle events for refused line-side operations
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            und_q <= 1'b0;
        end else begin
            ovr_q <= rx_push && rx_full && !flush_busy[Q_RX];
            und_q <= tx_pop && tx_empty && !flush_busy[Q_TX];
        end
    end

    // shifter-facing outputs and level marks
    always_comb begin
        tx_byte       = tx_head;
        tx_valid      = q_en && !tx_empty && !flush_busy[Q_TX];
        tx_level_low  = (tx_cnt <= CW'(LOW_MARK));
        rx_level_high = (rx_cnt >= CW'(HIGH_MARK));
        ev_overrun    = ovr_q;
        ev_underrun   = und_q;
    end

    // read data mux and error response for the access cycle
    always_comb begin
        bus_rdata = '0;
        bus_err   = 1'b0;
        if (rd_ctrl) begin
            bus_rdata[CTL_EN]      = q_en;
            bus_rdata[CTL_TXFLUSH] = flush_busy[Q_TX];
            bus_rdata[CTL_RXFLUSH] = flush_busy[Q_RX];
        end else if (rd_level) begin
            bus_rdata[LVL_TX_LSB +: CW] = tx_cnt;
            bus_rdata[LVL_RX_LSB +: CW] = rx_cnt;
        end else if (rd_rxw) begin
            if (rx_empty) begin
                bus_err = empty_rd_err_en;
            end else begin
                bus_rdata[RX_ENTRY_W-1:0] = rx_head;
            end
        end
    end

    // R7: an error response only ever answers a read of an empty queue
    p_err_on_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (rd_rxw && rx_empty));

    // R5: an overrun event follows a strobe into a full receive queue
    p_overrun_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && q_en && rx_full && !flush_busy[Q_RX]) |=> ev_overrun);

    // R5: a dropped character leaves the receive count at the depth
    p_overrun_keeps_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && rx_full && !rd_rxw && !flush_busy[Q_RX]) |=> rx_full);

    // R6: an underrun event follows a take from an empty transmit queue
    p_underrun_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_take && q_en && tx_empty && !flush_busy[Q_TX]) |=> ev_underrun);

    // R9: while disabled the receive count cannot rise
    p_disabled_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_en && !flush_busy[Q_RX]) |=> (rx_cnt <= $past(rx_cnt)));

endmodule

// File: tb/serial_fifo_pair_test.sv
`timescale 1ns/1ps
module serial_fifo_pair_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        empty_rd_err_en = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_valid;
    logic        tx_take = 1'b0;
    logic        rx_strobe = 1'b0;
    logic [7:0]  rx_char = '0;
    logic        rx_parity_err = 1'b0;
    logic        rx_frame_err = 1'b0;
    logic        tx_level_low;
    logic        rx_level_high;
    logic        ev_overrun;
    logic        ev_underrun;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam int DEPTH = 16;
    localparam int CLR   = 2;

    always #2 clk = ~clk;

    serial_fifo_pair uut (
        .clk (clk), .rst_n (rst_n),
        .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .bus_err (bus_err),
        .empty_rd_err_en (empty_rd_err_en),
        .tx_byte (tx_byte), .tx_valid (tx_valid), .tx_take (tx_take),
        .rx_strobe (rx_strobe), .rx_char (rx_char),
        .rx_parity_err (rx_parity_err), .rx_frame_err (rx_frame_err),
        .tx_level_low (tx_level_low), .rx_level_high (rx_level_high),
        .ev_overrun (ev_overrun), .ev_underrun (ev_underrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int tx_pat(int i);
        return (i * 37 + 5) & 255;
    endfunction

    function automatic int rx_pat(int i);
        return (((i >> 1) & 1) << 9) | ((i & 1) << 8) | ((i * 53 + 11) & 255);
    endfunction

    // one write access, released just after the edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // one read access, sampled in the access cycle
    task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1; d = bus_rdata; e = bus_err;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic take_one();
        @(negedge clk); tx_take = 1'b1;
        @(posedge clk); #1; tx_take = 1'b0;
    endtask

    task automatic rx_send(input int v);
        @(negedge clk);
        rx_strobe = 1'b1; rx_char = v[7:0];
        rx_parity_err = v[8]; rx_frame_err = v[9];
        @(posedge clk); #1; rx_strobe = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic e;
        int exp_cnt;

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        bus_read(8'h04, d, e); chk(d == 0, "R1 level", d, 0);
        bus_read(8'h00, d, e); chk(d == 0, "R1 ctrl", d, 0);
        chk(tx_valid == 0 && tx_level_low == 1 && rx_level_high == 0,
            "R1 outputs", {tx_valid, tx_level_low, rx_level_high}, 3'b010);
        chk(ev_overrun == 0 && ev_underrun == 0, "R1 events",
            {ev_overrun, ev_underrun}, 0);

        // R9 disabled: nothing stored
        bus_write(8'h20, 32'hAA);
        rx_send(32'h55);
        bus_read(8'h04, d, e); chk(d == 0, "R9 disabled level", d, 0);
        chk(tx_valid == 0, "R9 tx_valid", tx_valid, 0);

        bus_write(8'h00, 32'h1);

        // R2 R4 R10 transmit fill sweep past full
        for (int i = 0; i < DEPTH + 2; i++) begin
            bus_write(8'h20 + 8'((i % 8) * 4), 32'(tx_pat(i)) | 32'hFF00);
            exp_cnt = (i + 1 > DEPTH) ? DEPTH : i + 1;
            bus_read(8'h04, d, e);
            chk(d == 32'(exp_cnt), "R2/R4 tx count", d, exp_cnt);
            chk(tx_level_low == (exp_cnt <= 4), "R10 tx low mark",
                tx_level_low, exp_cnt <= 4);
        end

        // R2 R4 drain in order, dropped bytes absent
        for (int i = 0; i < DEPTH; i++) begin
            #1;
            chk(tx_valid == 1 && tx_byte == 8'(tx_pat(i)), "R2 tx order",
                tx_byte, tx_pat(i));
            take_one();
        end
        chk(tx_valid == 0, "R4 tx empty after drain", tx_valid, 0);

        // R6 underrun
        take_one();
        @(negedge clk); #1;
        chk(ev_underrun == 1, "R6 underrun pulse", ev_underrun, 1);
        @(negedge clk); #1;
        chk(ev_underrun == 0, "R6 underrun one cycle", ev_underrun, 0);
        bus_read(8'h04, d, e); chk(d == 0, "R6 count stays 0", d, 0);

        // R3 R5 R10 receive fill sweep past full
        for (int i = 0; i < DEPTH + 2; i++) begin
            rx_send(rx_pat(i));
            exp_cnt = (i + 1 > DEPTH) ? DEPTH : i + 1;
            @(negedge clk); #1;
            chk(ev_overrun == (i >= DEPTH), "R5 overrun pulse", ev_overrun, i >= DEPTH);
            chk(rx_level_high == (exp_cnt >= 12), "R10 rx high mark",
                rx_level_high, exp_cnt >= 12);
            bus_read(8'h04, d, e);
            chk(d == 32'(exp_cnt << 8), "R3/R5 rx count", d, exp_cnt << 8);
        end

        // R3 R5 read back entries with flags, dropped ones absent
        for (int i = 0; i < DEPTH; i++) begin
            bus_read(8'h40 + 8'((i % 8) * 4), d, e);
            chk(d == 32'(rx_pat(i)) && e == 0, "R3 rx entry", d, rx_pat(i));
        end

        // R7 empty reads
        empty_rd_err_en = 1'b0;
        bus_read(8'h40, d, e);
        chk(d == 0 && e == 0, "R7 empty read no err", {d[7:0], e}, 0);
        empty_rd_err_en = 1'b1;
        bus_read(8'h44, d, e);
        chk(d == 0 && e == 1, "R7 empty read err", {d[7:0], e}, 1);
        empty_rd_err_en = 1'b0;
        bus_read(8'h04, d, e); chk(d == 0, "R7 count stays 0", d, 0);

        // R8 flush of transmit only
        for (int i = 0; i < 3; i++) begin
            bus_write(8'h20, 32'(i));
            rx_send(rx_pat(i));
        end
        bus_write(8'h00, 32'h5);
        bus_read(8'h00, d, e); chk(d == 32'h5, "R8 tx flush busy", d, 5);
        repeat (CLR) @(posedge clk);
        bus_read(8'h00, d, e); chk(d == 32'h1, "R8 tx flush done", d, 1);
        bus_read(8'h04, d, e); chk(d == 32'h300, "R8 rx kept", d, 32'h300);

        // R8 flush of both
        bus_write(8'h20, 32'h7);
        bus_write(8'h00, 32'hD);
        bus_read(8'h00, d, e); chk(d == 32'hD, "R8 both busy", d, 32'hD);
        repeat (CLR) @(posedge clk);
        bus_read(8'h00, d, e); chk(d == 32'h1, "R8 both done", d, 1);
        bus_read(8'h04, d, e); chk(d == 0, "R8 both empty", d, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule